// File: doc/BRIEF.md
# Scrub Sequencer for the Parallel Configuration Port

This block refreshes the configuration of an FPGA that is already running. It does not erase configuration memory first. It acts as master of the target's 8-bit slave parallel configuration port and generates the port clock itself: one clock pulse per byte, raised only once the byte is settled on the bus. A byte source supplies the refresh stream through a valid/ready handshake. That stream already opens with the write of the chosen start frame (major column number, minor frame number) into the target's frame address register. A zero address means the whole device is refreshed.

Every scrub is wrapped in two aborts. The sequencer first pulls chip select low with the read/write line low and the data bus released. It then raises read/write, which is the abort request, and clocks the target four times. On each clock it collects one byte of the 32-bit status word that the target returns on the bus. Releasing chip select ends the abort.

Streaming stops at the first of two events: the source flags a byte as the end of the stream, or a fixed byte count is reached. The byte count is placed just before the block-RAM column, so memory contents survive. The closing abort follows at once. The most recent status word is kept, and two of its bits are decoded into flags. A missing sync word after the opening abort raises an error flag when the host says a full configuration preceded the scrub.

Top module: `scrub_seq`

## Requirements
- R1: After reset, csB is high and cclk, rdwrB, dataOe, inReady, done, syncSeen, abortSeen and syncErr are low.
- R2: A start pulse begins with an abort. csB falls while rdwrB is low and dataOe is low, and no frame byte is clocked before that abort has ended.
- R3: Each abort gives exactly ABORT_BEATS (default 4) rising edges of cclk while rdwrB is high and csB is low. csB then rises while rdwrB is still high, and rdwrB returns low only after that.
- R4: The byte on dataIn is captured at the end of every high phase of cclk during an abort. The first byte is the most significant. When csB rises, statusWord holds the completed word of the most recent abort.
- R5: syncSeen equals bit 6 of the last status byte captured (bit 6 = 1 means the sync word was received). abortSeen is the inverse of bit 4 of that byte (bit 4 = 0 means an abort occurred).
- R6: syncErr is cleared by start. At the end of the opening abort it is set if expectSync is high and bit 6 of the last captured byte is 0. The closing abort leaves it unchanged.
- R7: Source bytes reach dataOut in order. Each is taken from the source only when inValid and inReady are both high, and each is clocked by a rising edge of cclk with csB low, rdwrB low and dataOe high.
- R8: The byte taken with inLast high is the last one clocked to the port, and the closing abort follows it.
- R9: Once STOP_BYTES bytes have been taken, inReady stays low and the closing abort starts, whether or not inLast was seen.
- R10: If busy is high at the end of a cclk high phase during streaming, the same byte is held on dataOut and clocked again on the next pulse.
- R11: rdwrB is high only while dataOe is low.
- R12: done pulses high for one cycle after the closing abort has ended. The block then returns to its reset port state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a scrub |
| expectSync | input | 1 | A full configuration preceded this scrub |
| inValid | input | 1 | Source byte valid |
| inReady | output | 1 | Sequencer accepts a source byte |
| inData | input | 8 | Source byte |
| inLast | input | 1 | Source byte is the last of the stream |
| cclk | output | 1 | Controlled configuration clock |
| csB | output | 1 | Port chip select, active low |
| rdwrB | output | 1 | Port direction, high = read / abort request |
| dataOut | output | 8 | Byte driven onto the port bus |
| dataIn | input | 8 | Byte returned by the target on the port bus |
| dataOe | output | 1 | Output enable for dataOut |
| busy | input | 1 | Target not ready, byte must be repeated |
| statusWord | output | 32 | Status word from the last abort |
| syncSeen | output | 1 | Last status reports sync word received |
| abortSeen | output | 1 | Last status reports an abort |
| syncErr | output | 1 | Sync word missing after the opening abort |
| done | output | 1 | One-cycle end-of-scrub pulse |

## Verification
Two stop conditions can fall on the same byte: the end-of-stream flag and the byte-count limit. A busy stall can also land on that final byte. The bench sweeps the marker position across every byte up to two past the limit, including the position equal to the limit. On some runs it stalls the final byte for two pulses. Each run is judged by the exact number and contents of bytes seen at the target, the number of source bytes consumed, and exactly two aborts of four beats each with one done pulse.

// File: rtl/scrub_seq_pkg.sv
package scrub_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_AB_ENTER,
    S_AB_CLK,
    S_AB_EXIT,
    S_AB_REL,
    S_FETCH,
    S_PULSE,
    S_DONE
  } seqState_t;

  typedef struct packed {
    logic clrFlags;
    logic clrCount;
    logic loadByte;
    logic shiftStatus;
    logic evalOpen;
    logic evalClose;
  } dpCtrl_t;

endpackage

// File: rtl/scrub_seq_ctrl.sv
module scrub_seq_ctrl
  import scrub_seq_pkg::*;
#(
  parameter int ABORT_BEATS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    inValid,
  input  logic    countFull,
  input  logic    lastPending,
  input  logic    busy,
  output logic    inReady,
  output logic    cclk,
  output logic    csB,
  output logic    rdwrB,
  output logic    dataOe,
  output logic    done,
  output dpCtrl_t dp
);

  localparam int BW = (ABORT_BEATS > 1) ? $clog2(ABORT_BEATS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(ABORT_BEATS - 1);

  seqState_t state;
  logic phase;
  logic closing;
  logic [BW-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= 1'b0;
      closing <= 1'b0;
      beat    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_AB_ENTER;
          closing <= 1'b0;
        end
        S_AB_ENTER: begin
          state <= S_AB_CLK;
          phase <= 1'b0;
          beat  <= '0;
        end
        S_AB_CLK: begin
          if (!phase) phase <= 1'b1;
          else begin
            phase <= 1'b0;
            if (beat == LAST_BEAT) state <= S_AB_EXIT;
            else beat <= beat + 1'b1;
          end
        end
        S_AB_EXIT: state <= S_AB_REL;
        S_AB_REL:  state <= closing ? S_DONE : S_FETCH;
        S_FETCH: begin
          if (countFull) begin
            state   <= S_AB_ENTER;
            closing <= 1'b1;
          end else if (inValid) begin
            state <= S_PULSE;
            phase <= 1'b0;
          end
        end
        S_PULSE: begin
          if (!phase) phase <= 1'b1;
          else begin
            phase <= 1'b0;
            if (!busy) begin
              if (lastPending) begin
                state   <= S_AB_ENTER;
                closing <= 1'b1;
              end else begin
                state <= S_FETCH;
              end
            end
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dp             = '0;
    dp.clrFlags    = (state == S_IDLE) && start;
    dp.clrCount    = (state == S_IDLE) && start;
    dp.loadByte    = (state == S_FETCH) && !countFull && inValid;
    dp.shiftStatus = (state == S_AB_CLK) && phase;
    dp.evalOpen    = (state == S_AB_EXIT) && !closing;
    dp.evalClose   = (state == S_AB_EXIT) && closing;
  end

  assign csB     = !((state == S_AB_ENTER) || (state == S_AB_CLK) ||
                     (state == S_FETCH) || (state == S_PULSE));
  assign rdwrB   = (state == S_AB_CLK) || (state == S_AB_EXIT);
  assign dataOe  = (state == S_FETCH) || (state == S_PULSE);
  assign cclk    = ((state == S_AB_CLK) || (state == S_PULSE)) && phase;
  assign inReady = (state == S_FETCH) && !countFull;
  assign done    = (state == S_DONE);

  // checker: pulses seen while the abort request is up
  logic [7:0] chkBeats;
  always_ff @(posedge clk) begin
    if (!rstN)               chkBeats <= '0;
    else if (csB)            chkBeats <= '0;
    else if (cclk && rdwrB)  chkBeats <= chkBeats + 8'd1;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    rdwrB |-> !dataOe); // R11
  AST_ABORT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csB) && $past(rdwrB)) |-> (chkBeats == 8'(ABORT_BEATS))); // R3
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdwrB) |-> csB); // R3
  AST_READY_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (dataOe && !csB && !rdwrB)); // R7

endmodule

// File: rtl/scrub_seq_datapath.sv
module scrub_seq_datapath
  import scrub_seq_pkg::*;
#(
  parameter int STOP_BYTES  = 12,
  parameter int ABORT_BEATS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       dp,
  input  logic [7:0]    inData,
  input  logic          inLast,
  input  logic [7:0]    dataIn,
  input  logic          expectSync,
  output logic [7:0]    dataOut,
  output logic          lastPending,
  output logic          countFull,
  output logic [8*ABORT_BEATS-1:0] statusWord,
  output logic          syncSeen,
  output logic          abortSeen,
  output logic          syncErr
);

  localparam int SW = 8 * ABORT_BEATS;
  localparam int CW = $clog2(STOP_BYTES + 1);
  localparam logic [CW-1:0] STOP_AT = CW'(STOP_BYTES);

  logic [CW-1:0] byteCount;
  logic [SW-1:0] shiftReg;

  assign countFull = (byteCount == STOP_AT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut     <= '0;
      lastPending <= 1'b0;
      byteCount   <= '0;
    end else begin
      if (dp.clrCount) byteCount <= '0;
      else if (dp.loadByte) byteCount <= byteCount + 1'b1;
      if (dp.loadByte) begin
        dataOut     <= inData;
        lastPending <= inLast;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      statusWord <= '0;
      syncSeen   <= 1'b0;
      abortSeen  <= 1'b0;
      syncErr    <= 1'b0;
    end else begin
      if (dp.shiftStatus) shiftReg <= (shiftReg << 8) | SW'(dataIn);
      if (dp.evalOpen || dp.evalClose) begin
        statusWord <= shiftReg;
        syncSeen   <= shiftReg[6];
        abortSeen  <= !shiftReg[4];
      end
      if (dp.clrFlags) syncErr <= 1'b0;
      else if (dp.evalOpen) syncErr <= expectSync && !shiftReg[6];
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= STOP_AT); // R9
  AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    countFull |-> !dp.loadByte); // R9
  AST_SYNCERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncErr) |-> ($past(dp.evalOpen) && $past(expectSync))); // R6

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_seq_pkg::*;
#(
  parameter int STOP_BYTES  = 12,
  parameter int ABORT_BEATS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        expectSync,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        cclk,
  output logic        csB,
  output logic        rdwrB,
  output logic [7:0]  dataOut,
  input  logic [7:0]  dataIn,
  output logic        dataOe,
  input  logic        busy,
  output logic [8*ABORT_BEATS-1:0] statusWord,
  output logic        syncSeen,
  output logic        abortSeen,
  output logic        syncErr,
  output logic        done
);

  dpCtrl_t dp;
  logic countFull;
  logic lastPending;

  scrub_seq_ctrl #(.ABORT_BEATS(ABORT_BEATS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .countFull(countFull), .lastPending(lastPending), .busy(busy),
    .inReady(inReady), .cclk(cclk), .csB(csB), .rdwrB(rdwrB),
    .dataOe(dataOe), .done(done), .dp(dp)
  );

  scrub_seq_datapath #(.STOP_BYTES(STOP_BYTES), .ABORT_BEATS(ABORT_BEATS)) uDp (
    .clk(clk), .rstN(rstN), .dp(dp), .inData(inData), .inLast(inLast),
    .dataIn(dataIn), .expectSync(expectSync), .dataOut(dataOut),
    .lastPending(lastPending), .countFull(countFull),
    .statusWord(statusWord), .syncSeen(syncSeen), .abortSeen(abortSeen),
    .syncErr(syncErr)
  );

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cclk && busy && dataOe) |=> $stable(dataOut)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csB && !rdwrB && !dataOe)); // R12

endmodule

// File: tb/sim_scrub_seq.sv
module sim_scrub_seq;

  localparam int STOP = 6;
  localparam int SRC_MAX = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic expectSync = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;
  logic cclk, csB, rdwrB, dataOe, done;
  logic [7:0] dataOut;
  logic [7:0] dataIn = '0;
  logic busy = 1'b0;
  logic [31:0] statusWord;
  logic syncSeen, abortSeen, syncErr;

  always #5 clk = ~clk;

  scrub_seq #(.STOP_BYTES(STOP), .ABORT_BEATS(4)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .expectSync(expectSync),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inLast(inLast),
    .cclk(cclk), .csB(csB), .rdwrB(rdwrB), .dataOut(dataOut), .dataIn(dataIn),
    .dataOe(dataOe), .busy(busy), .statusWord(statusWord), .syncSeen(syncSeen),
    .abortSeen(abortSeen), .syncErr(syncErr), .done(done)
  );

  int checks = 0;
  int errors = 0;

  // run context
  int runId = 0;
  int lastAt = 1;
  int stallAt = -1;
  int stallLeft = 0;
  int gapMod = 2;
  bit srcEnable = 0;

  // observations
  int srcIdx = 0;
  bit fire = 0;
  int cyc = 0;
  int nRec = 0;
  logic [7:0] rec [SRC_MAX];
  int abortIdx = 0;
  int beat = 0;
  int beatsLog [2];
  int orderErr = 0;
  int contention = 0;
  int doneCnt = 0;
  bit prevCsB = 1'b1;

  function automatic logic [7:0] pat(input int k);
    case (k % 4)
      0: pat = 8'hDF;
      1: pat = 8'hCF;
      2: pat = 8'h8F;
      default: pat = 8'h9F;
    endcase
  endfunction

  function automatic logic [7:0] sb(input int r, input int i);
    sb = 8'((r * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target model on the configuration port
  always @(posedge cclk) begin
    if (!csB && rdwrB) begin
      dataIn = pat(runId + abortIdx + beat);
      beat++;
      busy = 1'b0;
    end else if (!csB) begin
      if (abortIdx == 0) orderErr++;
      if (!dataOe) contention++;
      if (stallLeft > 0 && nRec == stallAt) begin
        busy = 1'b1;
        stallLeft--;
      end else begin
        busy = 1'b0;
        if (nRec < SRC_MAX) rec[nRec] = dataOut;
        nRec++;
      end
    end
  end

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (csB && !prevCsB) begin
      if (abortIdx < 2) beatsLog[abortIdx] = beat;
      if (!rdwrB) orderErr++;
      abortIdx++;
      beat = 0;
    end
    if (rdwrB && dataOe) contention++;
    if (done) doneCnt++;
    prevCsB = csB;
  end

  // byte source
  initial begin
    forever begin
      @(negedge clk);
      if (fire) srcIdx++;
      cyc++;
      inValid = srcEnable && (srcIdx < SRC_MAX) && ((cyc % gapMod) != 0);
      inData  = sb(runId, srcIdx);
      inLast  = (srcIdx == lastAt - 1);
      fire    = inValid && inReady;
    end
  end

  task automatic runScrub(input int la, input int sAt, input int sLen, input bit expS);
    int expN;
    int t;
    bit allOk;
    logic [31:0] closeWord;
    logic [7:0] openLast;
    @(posedge clk);
    lastAt = la; stallAt = sAt; stallLeft = sLen; gapMod = 2 + (runId % 3);
    srcIdx = 0; fire = 0; nRec = 0; abortIdx = 0; beat = 0; orderErr = 0;
    contention = 0; doneCnt = 0; beatsLog[0] = 0; beatsLog[1] = 0;
    expectSync = expS; srcEnable = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    t = 0;
    while (doneCnt == 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    srcEnable = 0;
    expN = (la < STOP) ? la : STOP;
    closeWord = {pat(runId + 1), pat(runId + 2), pat(runId + 3), pat(runId + 4)};
    openLast = pat(runId + 3);
    chk("R12", "done pulses", doneCnt, 1);
    chk("R12", "port idle after", {csB, rdwrB, dataOe, cclk}, 4'b1000);
    chk("R8/R9", "bytes clocked", nRec, expN);
    chk("R7", "bytes consumed", srcIdx, expN);
    allOk = 1;
    for (int i = 0; i < expN && i < SRC_MAX; i++) if (rec[i] !== sb(runId, i)) allOk = 0;
    chk("R7", "byte contents in order", allOk, 1);
    chk("R2", "abort count and order", {abortIdx, orderErr}, {32'd2, 32'd0});
    chk("R3", "opening abort beats", beatsLog[0], 4);
    chk("R3", "closing abort beats", beatsLog[1], 4);
    chk("R11", "contention events", contention, 0);
    chk("R4", "status word", statusWord, closeWord);
    chk("R5", "syncSeen", syncSeen, closeWord[6]);
    chk("R5", "abortSeen", abortSeen, !closeWord[4]);
    chk("R6", "syncErr", syncErr, expS && !openLast[6]);
    if (sLen > 0) chk("R10", "stall consumed", stallLeft, 0);
    runId++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ports", {csB, cclk, rdwrB, dataOe, inReady, done}, 6'b100000);
    chk("R1", "reset flags", {syncSeen, abortSeen, syncErr}, 3'b000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", {csB, cclk, rdwrB, dataOe, inReady}, 5'b10000);
    for (int la = 1; la <= 8; la++) begin
      for (int sw = 0; sw < 2; sw++) begin
        int nExp;
        nExp = (la < STOP) ? la : STOP;
        if (sw == 1) runScrub(la, nExp - 1, 2, 1'b1);
        else if (la % 2 == 1) runScrub(la, 0, 1, 1'b0);
        else runScrub(la, -1, 0, 1'b1);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule